// File: doc/BRIEF.md
# Programmable-Order Cascaded Integrator

This block is the accumulate half of a cascaded-integrator decimation filter. It runs at the input sample clock. It holds a chain of up to `NUM_STAGES` accumulator stages, and each stage is wider than the one before it. Every stage is an adder, a feedback gate and a register. On each clock edge a stage adds its input to its own previous value when its feedback is enabled. When its feedback is disabled, the stage only registers its input.

A small order field sets how many of the leading stages accumulate. A value of N turns on the first N stages. The remaining stages act as plain pipeline registers. A bypass bit and a synchronous clear input each remove the feedback from every stage at once. The widest stage drives the output, which feeds a decimation register further downstream.

Top module: `int_cascade`

## Requirements
- R1: While `rst_ni` is low, every stage register is zero and `acc_o` reads zero. This holds on the first rising clock edge after release.
- R2: Stage k (0-based) has feedback enabled exactly when `order_i > k` and neither `bypass_i` nor `clr_i` is high. Any order value of `NUM_STAGES` or more (6 and 7 included) enables every stage.
- R3: An enabled stage loads its input plus its previous value. The sum wraps in two's complement at that stage's width, with no saturation.
- R4: A stage with feedback disabled loads its input unchanged. With order 0, `acc_o` equals the sample applied `NUM_STAGES` edges earlier.
- R5: `bypass_i` high removes the feedback of all stages, whatever the value of `order_i`.
- R6: `clr_i` high removes the feedback of all stages in the same way as bypass. Accumulated sums are therefore flushed rather than held.
- R7: Each stage sign-extends its input to its own width. The width of stage k is `IN_W + (OUT_W-IN_W)*k/(NUM_STAGES-1)`, which gives 26, 36, 46, 56 and 66 bits by default.
- R8: The chain always has `NUM_STAGES` register stages of latency from `sample_i` to `acc_o`, whatever the order setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | IN_W | Signed input sample |
| order_i | input | ORD_W | Number of accumulating stages |
| bypass_i | input | 1 | Removes the feedback of every stage |
| clr_i | input | 1 | Synchronous clear of all feedback paths |
| acc_o | output | OUT_W | Signed value of the last stage |

## Verification
The hardest condition to reach is a wrap-around in an early, narrow stage that then travels intact through the wider stages that follow. A long random run rarely isolates this case. The bench first flushes the chain with bypass. It then drives the largest positive sample into a single accumulating stage for two edges, which forces that stage to wrap to -2. Finally it sets the order to zero and checks that exactly -2, sign-extended, reaches the 66-bit output. Alongside this, a software model of truncating accumulators tracks every cycle of sweeps over all eight order codes, over order changes in the middle of a stream, and over bypass and clear.

// File: rtl/int_cascade_pkg.sv
package int_cascade_pkg;
  // width of stage k, linear growth from in_w to out_w
  function automatic int stage_w(input int k, input int in_w, input int out_w, input int n);
    if (n <= 1) return out_w;
    return in_w + ((out_w - in_w) * k) / (n - 1);
  endfunction
endpackage

// File: rtl/int_order_decode.sv
module int_order_decode #(
  parameter int NUM_STAGES = 5,
  parameter int ORD_W      = 3
) (
  input  logic [ORD_W-1:0]      order_i,
  input  logic                  bypass_i,
  input  logic                  clr_i,
  output logic [NUM_STAGES-1:0] fb_en_o
);
  logic gate_off;
  assign gate_off = bypass_i | clr_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_dec
    assign fb_en_o[k] = !gate_off && ({1'b0, order_i} > (ORD_W+1)'(k));
  end
endmodule

// File: rtl/int_stage.sv
module int_stage #(
  parameter int IN_W = 26,
  parameter int W    = 26
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] d_i,
  input  logic            fb_en_i,
  output logic [W-1:0]    q_o
);
  logic [W-1:0] ext;
  logic [W-1:0] fb;
  logic [W-1:0] q;

  assign ext = W'($signed(d_i));
  assign fb  = fb_en_i ? q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ext + fb;   // wraps at W
  end

  assign q_o = q;
endmodule

// File: rtl/int_cascade.sv
module int_cascade
  import int_cascade_pkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int IN_W       = 26,
  parameter int OUT_W      = 66,
  parameter int ORD_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  sample_i,
  input  logic [ORD_W-1:0] order_i,
  input  logic             bypass_i,
  input  logic             clr_i,
  output logic [OUT_W-1:0] acc_o
);
  logic [NUM_STAGES-1:0] stage_en;
  logic [OUT_W-1:0]      chain [NUM_STAGES];

  int_order_decode #(
    .NUM_STAGES(NUM_STAGES),
    .ORD_W     (ORD_W)
  ) u_dec (
    .order_i (order_i),
    .bypass_i(bypass_i),
    .clr_i   (clr_i),
    .fb_en_o (stage_en)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    localparam int SW = stage_w(k, IN_W, OUT_W, NUM_STAGES);
    logic [SW-1:0] q;

    if (k == 0) begin : g_first
      int_stage #(.IN_W(IN_W), .W(SW)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sample_i),
        .fb_en_i(stage_en[k]),
        .q_o    (q)
      );
    end else begin : g_next
      localparam int PW = stage_w(k - 1, IN_W, OUT_W, NUM_STAGES);
      int_stage #(.IN_W(PW), .W(SW)) u_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (chain[k-1][PW-1:0]),
        .fb_en_i(stage_en[k]),
        .q_o    (q)
      );
    end

    assign chain[k] = OUT_W'($signed(q));
  end

  assign acc_o = chain[NUM_STAGES-1];
endmodule

// File: rtl/int_cascade_chk.sv
module int_cascade_chk #(
  parameter int NUM_STAGES = 5,
  parameter int IN_W       = 26,
  parameter int OUT_W      = 66,
  parameter int ORD_W      = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [IN_W-1:0]       sample_i,
  input logic [ORD_W-1:0]      order_i,
  input logic                  bypass_i,
  input logic                  clr_i,
  input logic [OUT_W-1:0]      acc_o,
  input logic [NUM_STAGES-1:0] stage_en
);
  localparam int CW = $clog2(NUM_STAGES + 1);

  logic          no_fb;
  logic [CW-1:0] off_cnt;
  logic [IN_W-1:0] hist [NUM_STAGES];

  assign no_fb = bypass_i | clr_i | (order_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt <= '0;
      for (int i = 0; i < NUM_STAGES; i++) hist[i] <= '0;
    end else begin
      if (!no_fb)                                off_cnt <= '0;
      else if (off_cnt < CW'(NUM_STAGES))        off_cnt <= off_cnt + 1'b1;
      hist[0] <= sample_i;
      for (int i = 1; i < NUM_STAGES; i++) hist[i] <= hist[i-1];
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> acc_o == '0);

  // R2
  thermo_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stage_en + 1'b1) & stage_en) == '0);

  // R2
  full_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_i >= ORD_W'(NUM_STAGES) && !bypass_i && !clr_i) |-> &stage_en);

  // R5 R6
  gated_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i || clr_i) |-> stage_en == '0);

  // R4 R8
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_cnt >= CW'(NUM_STAGES)) |-> acc_o == OUT_W'($signed(hist[NUM_STAGES-1])));
endmodule

bind int_cascade int_cascade_chk #(
  .NUM_STAGES(NUM_STAGES),
  .IN_W      (IN_W),
  .OUT_W     (OUT_W),
  .ORD_W     (ORD_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sample_i(sample_i),
  .order_i (order_i),
  .bypass_i(bypass_i),
  .clr_i   (clr_i),
  .acc_o   (acc_o),
  .stage_en(stage_en)
);

// File: tb/tb_int_cascade.sv
module tb_int_cascade;
  localparam int N     = 5;
  localparam int IN_W  = 26;
  localparam int OUT_W = 66;
  localparam int ORD_W = 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IN_W-1:0]  sample_i = '0;
  logic [ORD_W-1:0] order_i = '0;
  logic             bypass_i = 1'b0;
  logic             clr_i = 1'b0;
  logic [OUT_W-1:0] acc_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic signed [OUT_W-1:0] m [N];

  always #5 clk_i = ~clk_i;

  int_cascade #(.NUM_STAGES(N), .IN_W(IN_W), .OUT_W(OUT_W), .ORD_W(ORD_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .order_i(order_i),
    .bypass_i(bypass_i), .clr_i(clr_i), .acc_o(acc_o)
  );

  // R7: width of stage k
  function automatic int sw(input int k);
    return IN_W + ((OUT_W - IN_W) * k) / (N - 1);
  endfunction

  function automatic logic signed [OUT_W-1:0] trunc(input logic signed [OUT_W-1:0] v, input int w);
    return (v <<< (OUT_W - w)) >>> (OUT_W - w);
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] exp);
    n_tests++;
    if (acc_o !== exp) begin
      n_fail++;
      $display("FAIL %s acc_o=%h expected=%h", req, acc_o, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic [IN_W-1:0] s, input int ord, input bit byp, input bit clr,
                      input string req);
    logic signed [OUT_W-1:0] in_v;
    logic signed [OUT_W-1:0] fb;
    sample_i = s; order_i = ORD_W'(ord); bypass_i = byp; clr_i = clr;
    @(posedge clk_i);
    for (int k = N - 1; k >= 0; k--) begin
      in_v = (k == 0) ? OUT_W'($signed(s)) : m[k-1];
      fb   = (!byp && !clr && (k < ord)) ? m[k] : '0;
      m[k] = trunc(in_v + fb, sw(k));
    end
    @(negedge clk_i);
    check(req, m[N-1]);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m[k] = '0;
    // R1: reset state under active input
    sample_i = 26'h1ABCDEF; order_i = 3'd5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check("R1 reset", '0);
    end
    rst_ni = 1'b1;
    sample_i = '0;

    // R8 R4: order 0 impulse appears after exactly N edges
    step(26'h0000123, 0, 0, 0, "R8 impulse");
    for (int i = 0; i < N; i++) step('0, 0, 0, 0, "R8 R4 latency");

    // R2 R3: every order code, random samples
    for (int ord = 0; ord < 8; ord++)
      for (int i = 0; i < 40; i++)
        step(IN_W'($urandom), ord, 0, 0, "R2 R3 order sweep");

    // R2: order changed every cycle
    for (int i = 0; i < 200; i++)
      step(IN_W'($urandom), int'($urandom_range(0, 7)), 0, 0, "R2 order hop");

    // R5: bypass with full order
    for (int i = 0; i < 30; i++) step(IN_W'($urandom), 5, 1, 0, "R5 bypass");
    // R6: clear with full order
    for (int i = 0; i < 10; i++) step(IN_W'($urandom), 5, 0, 0, "R6 prefill");
    for (int i = 0; i < 30; i++) step(IN_W'($urandom), 5, 0, 1, "R6 clear");

    // R3 R7: wrap in stage 0 carried sign-extended to output
    for (int i = 0; i < N; i++) step('0, 5, 1, 0, "R5 flush");
    step(26'h1FFFFFF, 1, 0, 0, "R3 wrap a");
    step(26'h1FFFFFF, 1, 0, 0, "R3 wrap b");
    for (int i = 0; i < N - 1; i++) step('0, 0, 0, 0, "R3 wrap carry");
    check("R3 R7 wrap to -2", {{(OUT_W-2){1'b1}}, 2'b10});

    // R7: negative extremes, all stages accumulating
    for (int i = 0; i < 50; i++)
      step((i % 2) ? 26'h2000000 : 26'h1FFFFFF, 5, 0, 0, "R7 extremes");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule